// File: doc/BRIEF.md
# Character-Synchronous Receiver with Sync Hunt

This block receives a serial bit stream that is qualified by a one-cycle bit enable. It also gains character alignment from that stream. While hunting, it compares the most recent bits with a programmed sync pattern on every bit. The pattern length can be set anywhere from 2 to 16 bits. On a match it declares character sync, and framing begins with the following bit.

Once in sync, bits are packed least-significant first into characters of 1 to 8 bits. Each complete character appears on a parallel output with a one-cycle valid strobe. A sync pattern whose final bit completes a character is still recognised. It is then either dropped or delivered, according to a strip control. A hunt request abandons alignment at any time and discards any partly built character.

Top module: `bsync_rx`

## Requirements
- R1: After reset, `rx_valid`, `sync_acq` and `in_sync` are 0, and `rx_data` is 0.
- R2: While hunting, a match is declared on a bit when the last `sync_len` received bits, newest in bit 0 of the window, equal `sync_pat[sync_len-1:0]`. Bit `sync_len-1` of the pattern is the first bit on the line. `sync_len` values below 2 act as 2, and values above 16 act as 16.
- R3: A hunt match raises `sync_acq` for exactly one cycle, on the cycle after the edge that took the last pattern bit. From that cycle on, `in_sync` is 1. The matched pattern itself is never delivered as data.
- R4: No match is declared until at least `sync_len` bits have been received since reset or since the last hunt request. This holds even when the cleared history would equal the pattern.
- R5: In sync, the first bit after the sync pattern becomes bit 0 of a character. Each character holds `char_len` bits, where `char_len` is 1 to 8 (0 acts as 1, and values above 8 act as 8). Bits above `char_len-1` of `rx_data` are 0.
- R6: `rx_valid` pulses for one cycle, on the cycle after the edge that took a character's last bit, and `rx_data` holds that character.
- R7: A sync match whose last bit completes a character makes that character a sync character. With `strip_en`=1 it is not delivered. With `strip_en`=0 it is delivered like data.
- R8: A sync pattern that ends anywhere other than a character boundary has no effect on framing or on the delivered data.
- R9: `hunt_req` clears `in_sync` on the next cycle, discards any partial character, and restarts the bit count used by R4. It has priority over a bit arriving in the same cycle.
- R10: Cycles with `bit_en`=0 change no state, and the cycle after them shows neither `rx_valid` nor `sync_acq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| sync_len | input | 5 | Sync pattern length, 2 to 16 |
| sync_pat | input | 16 | Sync pattern, right-aligned, first line bit at bit `sync_len-1` |
| char_len | input | 4 | Data character length, 1 to 8 |
| strip_en | input | 1 | Drop sync characters found in frame |
| hunt_req | input | 1 | Return to hunt and discard any partial character |
| rx_data | output | 8 | Received character, LSB first on the line |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sync_acq | output | 1 | One-cycle pulse when sync is found while hunting |
| in_sync | output | 1 | Character framing is active |

## Verification
Every result is due one cycle after the clock edge that takes the deciding bit. This applies to `rx_valid`, `sync_acq` and the fall of `in_sync` after `hunt_req`. The bench drives inputs on the falling edge and samples one time unit after each rising edge, so it reads each registered result in the cycle it first appears. A driver task queues each expected character and counts each expected sync pulse before it sends the bits. A monitor pops the queue on each strobe, so an extra, missing or wrong character shows up as a miscompare. Idle gaps of varying length between bits confirm that only qualified bits advance the receiver.

// File: rtl/bsync_pkg.sv
// Shared constants and types for the character-synchronous receiver.
// Assumes: the sizes here are the defaults used by the top module.
package bsync_pkg;
    localparam int SYNC_MAX_DEF = 16;
    localparam int CHAR_MAX_DEF = 8;

    // Alignment state of the receiver
    typedef enum logic {
        LINE_HUNT   = 1'b0,
        LINE_FRAMED = 1'b1
    } line_state_e;
endpackage

// File: rtl/bsync_shifter.sv
// Bit history and sync comparator.
// Keeps the last SYNC_MAX line bits (newest in bit 0) and a saturating count
// of bits seen since the last clear. match_now is combinational and reports
// a match on the bit being taken in this cycle, so a match becomes visible in
// registered logic one cycle after the edge that takes the last pattern bit.
// Assumes: sync_len may be out of range; it is clamped to 2..SYNC_MAX.
module bsync_shifter #(
    parameter int SYNC_MAX = bsync_pkg::SYNC_MAX_DEF,
    localparam int LW = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic                clear,
    input  logic [LW-1:0]       sync_len,
    input  logic [SYNC_MAX-1:0] sync_pat,
    output logic                match_now
);
    logic [SYNC_MAX-1:0] hist_q;
    logic [SYNC_MAX-1:0] hist_next;
    logic [SYNC_MAX-1:0] win_mask;
    logic [LW-1:0]       fill_q;
    logic [LW-1:0]       fill_next;
    logic [LW-1:0]       eff_len;

    // Clamp the programmed length into the legal range
    always_comb begin
        if (sync_len < LW'(2))
            eff_len = LW'(2);
        else if (sync_len > LW'(SYNC_MAX))
            eff_len = LW'(SYNC_MAX);
        else
            eff_len = sync_len;
    end

    // One mask bit per window position, set below the effective length
    for (genvar i = 0; i < SYNC_MAX; i++) begin : g_mask
        assign win_mask[i] = (LW'(i) < eff_len);
    end

    // History and fill count as they will be after this bit
    always_comb begin
        hist_next = {hist_q[SYNC_MAX-2:0], bit_in};
        fill_next = (fill_q == LW'(SYNC_MAX)) ? fill_q : fill_q + LW'(1);
    end

    // Match only on a taken bit with enough history behind it
    assign match_now = bit_en && !clear && (fill_next >= eff_len) &&
                       (((hist_next ^ sync_pat) & win_mask) == '0);

    // Shift history and count bits, cleared on reset or hunt
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (bit_en) begin
            hist_q <= hist_next;
            fill_q <= fill_next;
        end
    end
endmodule

// File: rtl/bsync_framer.sv
// Character assembler.
// Packs line bits LSB first into a character of char_len bits. char_done
// and char_word are combinational for the bit being taken now. The word is
// masked to the effective length.
// Assumes: char_len is stable while a character is in progress and is
// clamped to 1..CHAR_MAX.
module bsync_framer #(
    parameter int CHAR_MAX = bsync_pkg::CHAR_MAX_DEF,
    localparam int LW = $clog2(CHAR_MAX + 1),
    localparam int CW = (CHAR_MAX > 1) ? $clog2(CHAR_MAX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                bit_in,
    input  logic                clear,
    input  logic [LW-1:0]       char_len,
    output logic                char_done,
    output logic [CHAR_MAX-1:0] char_word
);
    logic [CW-1:0]       cnt_q;
    logic [CHAR_MAX-1:0] acc_q;
    logic [CHAR_MAX-1:0] acc_next;
    logic [LW-1:0]       eff_len;

    // Clamp the programmed length into the legal range
    always_comb begin
        if (char_len == '0)
            eff_len = LW'(1);
        else if (char_len > LW'(CHAR_MAX))
            eff_len = LW'(CHAR_MAX);
        else
            eff_len = char_len;
    end

    // Place the incoming bit at the current position and mask unused bits
    for (genvar i = 0; i < CHAR_MAX; i++) begin : g_pack
        assign acc_next[i]  = (cnt_q == CW'(i)) ? bit_in : acc_q[i];
        assign char_word[i] = (LW'(i) < eff_len) ? acc_next[i] : 1'b0;
    end

    // This bit closes the character when it fills the last position
    assign char_done = step && !clear && ((LW'(cnt_q) + LW'(1)) == eff_len);

    // Advance bit position, restart after each full character or on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (char_done) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
            acc_q <= acc_next;
        end
    end
endmodule

// File: rtl/bsync_ctrl.sv
// Alignment control and output register.
// Moves from hunt to framed on a sync match, back to hunt on request, and
// registers the delivered character, dropping sync characters when
// stripping is on.
// Assumes: match and done come from the same taken bit in this cycle.
module bsync_ctrl #(
    parameter int CHAR_MAX = bsync_pkg::CHAR_MAX_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hunt_req,
    input  logic                match_now,
    input  logic                char_done,
    input  logic [CHAR_MAX-1:0] char_word,
    input  logic                strip_en,
    output logic                framed,
    output logic                acq_pulse,
    output logic                out_valid,
    output logic [CHAR_MAX-1:0] out_data
);
    import bsync_pkg::*;

    line_state_e state_q;

    assign framed = (state_q == LINE_FRAMED);

    // State and one-cycle strobes; the hunt request wins over a bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LINE_HUNT;
            acq_pulse <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            acq_pulse <= 1'b0;
            out_valid <= 1'b0;
            if (hunt_req) begin
                state_q <= LINE_HUNT;
            end else if (state_q == LINE_HUNT) begin
                if (match_now) begin
                    state_q   <= LINE_FRAMED;
                    acq_pulse <= 1'b1;
                end
            end else if (char_done) begin
                if (!(match_now && strip_en)) begin
                    out_valid <= 1'b1;
                    out_data  <= char_word;
                end
            end
        end
    end
endmodule

// File: rtl/bsync_rx.sv
// Character-synchronous receiver top.
// Hunts for a programmable sync pattern, then frames characters. The bit
// history keeps running in both states, so in-frame sync characters on a
// boundary can be recognised and optionally stripped.
// Assumes: configuration inputs change only while hunting.
module bsync_rx #(
    parameter int SYNC_MAX = bsync_pkg::SYNC_MAX_DEF,
    parameter int CHAR_MAX = bsync_pkg::CHAR_MAX_DEF,
    localparam int SLW = $clog2(SYNC_MAX + 1),
    localparam int CLW = $clog2(CHAR_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic [SLW-1:0]      sync_len,
    input  logic [SYNC_MAX-1:0] sync_pat,
    input  logic [CLW-1:0]      char_len,
    input  logic                strip_en,
    input  logic                hunt_req,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                sync_acq,
    output logic                in_sync
);
    logic                match_now;
    logic                char_done;
    logic [CHAR_MAX-1:0] char_word;
    logic                framer_clear;
    logic                framer_step;

    // Framing runs only while aligned; hunting keeps it empty
    assign framer_clear = hunt_req || !in_sync;
    assign framer_step  = bit_en && in_sync;

    bsync_shifter #(.SYNC_MAX(SYNC_MAX)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .clear     (hunt_req),
        .sync_len  (sync_len),
        .sync_pat  (sync_pat),
        .match_now (match_now)
    );

    bsync_framer #(.CHAR_MAX(CHAR_MAX)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (framer_step),
        .bit_in    (bit_in),
        .clear     (framer_clear),
        .char_len  (char_len),
        .char_done (char_done),
        .char_word (char_word)
    );

    bsync_ctrl #(.CHAR_MAX(CHAR_MAX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hunt_req  (hunt_req),
        .match_now (match_now),
        .char_done (char_done),
        .char_word (char_word),
        .strip_en  (strip_en),
        .framed    (in_sync),
        .acq_pulse (sync_acq),
        .out_valid (rx_valid),
        .out_data  (rx_data)
    );
endmodule

// File: rtl/bsync_rx_chk.sv
// Property checker for the receiver, attached to every bsync_rx instance.
// Assumes: it sees only top-level ports.
module bsync_rx_chk #(
    parameter int SYNC_MAX = bsync_pkg::SYNC_MAX_DEF,
    parameter int CHAR_MAX = bsync_pkg::CHAR_MAX_DEF,
    localparam int SLW = $clog2(SYNC_MAX + 1),
    localparam int CLW = $clog2(CHAR_MAX + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic                hunt_req,
    input logic [CLW-1:0]      char_len,
    input logic [CHAR_MAX-1:0] rx_data,
    input logic                rx_valid,
    input logic                sync_acq,
    input logic                in_sync
);
    // R3
    acq_enters_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_acq |-> (in_sync && !$past(in_sync)));

    // R3
    acq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_acq |=> !sync_acq);

    // R6
    valid_needs_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(in_sync) && !sync_acq));

    // R5
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(char_len) != '0 && $past(char_len) <= CLW'(CHAR_MAX))
        |-> ((rx_data >> $past(char_len)) == '0));

    // R9
    hunt_drops_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |=> (!in_sync && !rx_valid && !sync_acq));

    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!rx_valid && !sync_acq));
endmodule

bind bsync_rx bsync_rx_chk #(.SYNC_MAX(SYNC_MAX), .CHAR_MAX(CHAR_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .hunt_req (hunt_req),
    .char_len (char_len),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .sync_acq (sync_acq),
    .in_sync  (in_sync)
);

// File: tb/bsync_rx_tb.sv
// Scoreboard bench: driver tasks queue expected characters and sync pulses,
// and a monitor compares them as the receiver produces them.
module bsync_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [4:0]  sync_len = 5'd8;
    logic [15:0] sync_pat = 16'h0016;
    logic [3:0]  char_len = 4'd8;
    logic        strip_en = 1'b0;
    logic        hunt_req = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        sync_acq;
    logic        in_sync;

    int vectors = 0;
    int fails = 0;
    int acq_owed = 0;
    int gap_seed = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    bsync_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .sync_len(sync_len), .sync_pat(sync_pat), .char_len(char_len),
        .strip_en(strip_en), .hunt_req(hunt_req), .rx_data(rx_data),
        .rx_valid(rx_valid), .sync_acq(sync_acq), .in_sync(in_sync)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One qualified bit, then 0..2 idle cycles (R10)
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        for (int g = 0; g < gap_seed % 3; g++) @(negedge clk);
        gap_seed++;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    // Sync pattern, first line bit is bit len-1 (R2)
    task automatic send_sync(input int len, input bit expect_acq);
        if (expect_acq) acq_owed++;
        for (int i = len - 1; i >= 0; i--) send_bit(sync_pat[i]);
    endtask

    // Character sent LSB first; queued when it is expected to be delivered
    task automatic send_char(input logic [7:0] v, input int len, input bit deliver);
        logic [7:0] m;
        m = v & ((8'h1 << len) - 8'h1);
        if (len == 8) m = v;
        if (deliver) exp_q.push_back(m);
        for (int i = 0; i < len; i++) send_bit(m[i]);
    endtask

    task automatic pulse_hunt();
        @(negedge clk);
        hunt_req = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0;
    endtask

    // Monitor: compare every strobe against the scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected rx_valid", {8'h0, rx_data}, 16'hFFFF);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check("R5/R6/R7 rx_data", {8'h0, rx_data}, {8'h0, e});
                end
            end
            if (sync_acq) begin
                if (acq_owed == 0) check("R3 unexpected sync_acq", 16'h1, 16'h0);
                else begin
                    acq_owed--;
                    vectors++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1
        check("R1 rx_valid", {15'h0, rx_valid}, 16'h0);
        check("R1 sync_acq", {15'h0, sync_acq}, 16'h0);
        check("R1 in_sync", {15'h0, in_sync}, 16'h0);
        check("R1 rx_data", {8'h0, rx_data}, 16'h0);

        // R2 R3 R5 R7: 8-bit sync, 8-bit chars, stripping on
        strip_en = 1'b1;
        send_ones(10);
        check("R2 still hunting on ones", {15'h0, in_sync}, 16'h0);
        send_sync(8, 1'b1);
        @(posedge clk); #1;
        check("R3 in_sync after match", {15'h0, in_sync}, 16'h1);
        send_char(8'hA5, 8, 1'b1);
        send_char(8'h3C, 8, 1'b1);
        send_char(8'h00, 8, 1'b1);
        send_char(8'hFF, 8, 1'b1);
        send_sync(8, 1'b0);          // R7 stripped
        send_char(8'h81, 8, 1'b1);
        strip_en = 1'b0;
        send_char(8'h68, 8, 1'b1);   // R7 same sync bits delivered as data
        // R8: sync bits straddling a boundary are plain data
        send_char(8'h8F, 8, 1'b1);
        send_char(8'hF6, 8, 1'b1);

        // R9: hunt mid-character discards the partial bits
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pulse_hunt();
        #1;
        check("R9 in_sync cleared", {15'h0, in_sync}, 16'h0);

        // R2 R5 R7: 2-bit sync "01", 5-bit chars, stripping on
        sync_len = 5'd2; sync_pat = 16'h0001; char_len = 4'd5; strip_en = 1'b1;
        send_ones(4);
        send_sync(2, 1'b1);
        send_char(8'h1F, 5, 1'b1);
        send_char(8'h0A, 5, 1'b1);
        send_char(8'h12, 5, 1'b0);   // ends in "01": stripped sync char
        send_char(8'h05, 5, 1'b1);

        // R2 R5: 16-bit sync, 1-bit chars, no stripping
        pulse_hunt();
        sync_len = 5'd16; sync_pat = 16'hEB90; char_len = 4'd1; strip_en = 1'b0;
        send_ones(6);
        send_sync(16, 1'b1);
        send_char(8'h1, 1, 1'b1);
        send_char(8'h0, 1, 1'b1);
        send_char(8'h1, 1, 1'b1);

        // R4: all-zero pattern needs a full window after a hunt request
        pulse_hunt();
        sync_len = 5'd8; sync_pat = 16'h0000; char_len = 4'd8; strip_en = 1'b1;
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        @(posedge clk); #1;
        check("R4 no match before full window", {15'h0, in_sync}, 16'h0);
        acq_owed++;
        send_bit(1'b0);
        @(posedge clk); #1;
        check("R4 match on full window", {15'h0, in_sync}, 16'h1);
        send_char(8'h00, 8, 1'b0);   // R7 sync char stripped
        send_char(8'h01, 8, 1'b1);

        // R2 out-of-range length clamps to 2
        pulse_hunt();
        sync_len = 5'd0; sync_pat = 16'h0002; strip_en = 1'b0;
        send_bit(1'b0); send_bit(1'b0);
        acq_owed++;
        send_bit(1'b1); send_bit(1'b0);
        send_char(8'h5A, 8, 1'b1);

        repeat (6) @(posedge clk);
        #1;
        check("R6 all characters delivered", 16'(exp_q.size()), 16'h0);
        check("R3 all sync pulses seen", 16'(acq_owed), 16'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule